// File: doc/BRIEF.md
# Voiceband Modem Control Register Block

This block is the register front end of a voiceband modem's digital core. A parallel bus with an address, a data byte and a write strobe loads five 8-bit registers: four control registers and a tone register. The block decodes those registers into the modulation family and data rate handed to the modulator and demodulator. It steers the serial data paths according to a two-bit test-mode field. It also drives a clock pin that carries either the crystal clock or a clock at sixteen times the data rate.

The crystal clock `clk` also clocks the block itself. The modulator, the demodulator, the tone generator and the analog paths lie outside it. Toward them the block offers only the serial data pins `tx_mod` and `rx_demod`, the flags `rx_use_tx_carrier` and `line_mute`, the decoded `mode`, and the raw register bytes.

Top module: `modem_ctl`

## Requirements
- R1: Register 0 bits 6:5 pick the family: 10 is QAM, 00 is DPSK, 01 is FSK, and 11 is treated as DPSK. `mode` is encoded 0 = QAM 2400, 1 = DPSK 1200, 2 = DPSK 600, 3 = FSK V.23 and 4 = FSK V.21.
- R2: Register 0 bit 7 is the rate option. With 0 the result is QAM 2400, DPSK 1200 or FSK V.23. With 1 it is DPSK 600 or FSK V.21, and QAM stays at 2400.
- R3: With register 1 bits 1:0 at 00 (normal) or 01 (analog loopback), `tx_mod` follows `tx_data_in` and `rx_data_out` follows `rx_demod`.
- R4: With test mode 10 (remote digital loopback), `tx_mod` follows `rx_demod` and `tx_data_in` has no effect on any output.
- R5: With test mode 10, `rx_data_out` is held at mark (1).
- R6: With test mode 11 (local digital loopback), `rx_data_out` and `tx_mod` both follow `tx_data_in`.
- R7: `rx_use_tx_carrier` is 1 only with test mode 01. In every test mode, `line_mute` is the inverse of register 0 bit 1, which is the transmit enable.
- R8: A write to address 1 with bit 2 set clears registers 0 to 3 and the tone register (address 4) in the following cycle. Register 3 bit 2 keeps its previous value.
- R9: The clock pin carries `clk` when register 1 bit 3 is 0 or the family is FSK. When the bit is 1 in QAM or DPSK mode, the pin carries a 50 % clock whose high and low phases each last 144, 288 or 576 crystal cycles, for 2400, 1200 or 600 bit/s.
- R10: The clock pin changes source only while both sources are low, so it never emits a high pulse shorter than half a crystal cycle.
- R11: Register contents, and with them the routing, change on the clock edge that samples the write and not before. Writes to addresses 5 to 7 are ignored. `rst` clears every register, including register 3 bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, also the block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..3 control, 4 tone) |
| wr_data | input | 8 | Register write data |
| tx_data_in | input | 1 | Serial transmit data from the host side |
| rx_demod | input | 1 | Serial data recovered by the demodulator |
| tx_mod | output | 1 | Serial data to the modulator |
| rx_data_out | output | 1 | Serial receive data to the host side |
| rx_use_tx_carrier | output | 1 | Receiver tunes to the transmit carrier |
| line_mute | output | 1 | Mute the line output |
| mode | output | 3 | Decoded modulation mode and rate |
| clk_pin | output | 1 | Clock output pin |
| cfg_r0 | output | 8 | Register 0 contents |
| cfg_r1 | output | 8 | Register 1 contents |
| cfg_r2 | output | 8 | Register 2 contents |
| cfg_r3 | output | 8 | Register 3 contents |
| cfg_tone | output | 8 | Tone register contents |

## Verification
The properties assume that `rst` is asserted for at least one edge before the first write, so that the divider, the source select and the registers start from known values. They also assume that `wr_addr` and `wr_data` are stable at each rising edge of `clk` while `wr_en` is high. The stimulus changes every input one time unit after a rising edge and holds it through the next one. It waits several divided periods after each clock-pin setting before it measures phase lengths, so the switch-over latency that the low-phase rule introduces never overlaps a measurement.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;

    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int NREG = 5;

    // register addresses
    localparam int A_R0   = 0;
    localparam int A_R1   = 1;
    localparam int A_R3   = 3;

    // bit positions the decoders depend on
    localparam int B_TXEN  = 1;   // reg0
    localparam int B_FAMLO = 5;   // reg0 6:5
    localparam int B_OPT   = 7;   // reg0
    localparam int B_TMLO  = 0;   // reg1 1:0
    localparam int B_PDN   = 2;   // reg1
    localparam int B_CKSEL = 3;   // reg1
    localparam int B_KEEP  = 2;   // reg3, survives power-down

    typedef enum logic [1:0] {
        TM_NORMAL = 2'b00,
        TM_ALOOP  = 2'b01,
        TM_RLOOP  = 2'b10,
        TM_LLOOP  = 2'b11
    } tmode_e;

    typedef enum logic [2:0] {
        MD_QAM2400  = 3'd0,
        MD_DPSK1200 = 3'd1,
        MD_DPSK600  = 3'd2,
        MD_FSK_V23  = 3'd3,
        MD_FSK_V21  = 3'd4
    } mode_e;

    typedef struct packed {
        mode_e  mode;
        tmode_e tmode;
        logic   tx_en;
        logic   clk_sel;
    } ctl_s;

    function automatic mode_e decode_mode(logic [1:0] fam, logic opt);
        case (fam)
            2'b10:   return MD_QAM2400;
            2'b01:   return opt ? MD_FSK_V21 : MD_FSK_V23;
            default: return opt ? MD_DPSK600 : MD_DPSK1200;
        endcase
    endfunction

    function automatic logic is_phase_mod(mode_e m);
        return (m == MD_QAM2400) || (m == MD_DPSK1200) || (m == MD_DPSK600);
    endfunction

    // half period of the 16x clock in crystal cycles
    function automatic int unsigned half_div(mode_e m, int unsigned base);
        case (m)
            MD_DPSK1200: return base * 2;
            MD_DPSK600:  return base * 4;
            default:     return base;
        endcase
    endfunction

    function automatic logic [DW-1:0] keep_mask(int idx);
        logic [DW-1:0] msk;
        msk = '0;
        if (idx == A_R3) msk[B_KEEP] = 1'b1;
        return msk;
    endfunction

endpackage

// File: rtl/modem_ctl_regs.sv
module modem_ctl_regs
    import modem_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] reg_q [NREG],
    output ctl_s          ctl
);

    logic pd_hit;
    assign pd_hit = wr_en && (wr_addr == AW'(A_R1)) && wr_data[B_PDN];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                reg_q[g] <= '0;
            end else if (pd_hit) begin
                reg_q[g] <= reg_q[g] & keep_mask(g);
            end else if (wr_en && (wr_addr == AW'(g))) begin
                reg_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        ctl.mode    = decode_mode(reg_q[A_R0][B_FAMLO +: 2], reg_q[A_R0][B_OPT]);
        ctl.tmode   = tmode_e'(reg_q[A_R1][B_TMLO +: 2]);
        ctl.tx_en   = reg_q[A_R0][B_TXEN];
        ctl.clk_sel = reg_q[A_R1][B_CKSEL];
    end

endmodule

// File: rtl/modem_ctl_route.sv
module modem_ctl_route
    import modem_ctl_pkg::*;
(
    input  tmode_e tmode,
    input  logic   tx_en,
    input  logic   tx_data_in,
    input  logic   rx_demod,
    output logic   tx_mod,
    output logic   rx_data_out,
    output logic   rx_use_tx_carrier,
    output logic   line_mute
);

    always_comb begin
        tx_mod            = tx_data_in;
        rx_data_out       = rx_demod;
        rx_use_tx_carrier = 1'b0;
        line_mute         = ~tx_en;
        case (tmode)
            TM_ALOOP: rx_use_tx_carrier = 1'b1;
            TM_RLOOP: begin
                tx_mod      = rx_demod;
                rx_data_out = 1'b1;
            end
            TM_LLOOP: rx_data_out = tx_data_in;
            default: ;
        endcase
    end

endmodule

// File: rtl/modem_ctl_clkout.sv
module modem_ctl_clkout
    import modem_ctl_pkg::*;
#(
    parameter int unsigned HALF_BASE = 144
) (
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  clk_sel,
    output logic  div_sel,
    output logic  clk_pin
);

    localparam int unsigned HALF_MAX = HALF_BASE * 4;
    localparam int CW = $clog2(HALF_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half_w;
    logic          div_q;
    logic          want_div;

    assign half_w   = CW'(half_div(mode, HALF_BASE));
    assign want_div = clk_sel && is_phase_mod(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (cnt_q >= half_w - CW'(1)) begin
            cnt_q <= '0;
            div_q <= ~div_q;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // source change at the falling crystal edge, only while the divided clock is low
    always_ff @(negedge clk) begin
        if (rst) begin
            div_sel <= 1'b0;
        end else if (!div_q && (div_sel != want_div)) begin
            div_sel <= want_div;
        end
    end

    assign clk_pin = div_sel ? div_q : clk;

endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
    import modem_ctl_pkg::*;
#(
    parameter int unsigned HALF_BASE = 144
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       tx_data_in,
    input  logic       rx_demod,
    output logic       tx_mod,
    output logic       rx_data_out,
    output logic       rx_use_tx_carrier,
    output logic       line_mute,
    output logic [2:0] mode,
    output logic       clk_pin,
    output logic [7:0] cfg_r0,
    output logic [7:0] cfg_r1,
    output logic [7:0] cfg_r2,
    output logic [7:0] cfg_r3,
    output logic [7:0] cfg_tone
);

    logic [DW-1:0] reg_q [NREG];
    ctl_s          ctl;
    logic          div_sel;
    logic [1:0]    tmode_w;

    modem_ctl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .reg_q   (reg_q),
        .ctl     (ctl)
    );

    modem_ctl_route u_route (
        .tmode             (ctl.tmode),
        .tx_en             (ctl.tx_en),
        .tx_data_in        (tx_data_in),
        .rx_demod          (rx_demod),
        .tx_mod            (tx_mod),
        .rx_data_out       (rx_data_out),
        .rx_use_tx_carrier (rx_use_tx_carrier),
        .line_mute         (line_mute)
    );

    modem_ctl_clkout #(.HALF_BASE(HALF_BASE)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .mode    (ctl.mode),
        .clk_sel (ctl.clk_sel),
        .div_sel (div_sel),
        .clk_pin (clk_pin)
    );

    assign tmode_w  = ctl.tmode;
    assign mode     = ctl.mode;
    assign cfg_r0   = reg_q[0];
    assign cfg_r1   = reg_q[1];
    assign cfg_r2   = reg_q[2];
    assign cfg_r3   = reg_q[3];
    assign cfg_tone = reg_q[4];

endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [1:0] tmode_w,
    input logic       tx_data_in,
    input logic       rx_demod,
    input logic       tx_mod,
    input logic       rx_data_out,
    input logic [2:0] mode,
    input logic       div_sel,
    input logic [7:0] cfg_r0,
    input logic [7:0] cfg_r1,
    input logic [7:0] cfg_r2,
    input logic [7:0] cfg_r3,
    input logic [7:0] cfg_tone
);

    a_r4_remote_tx: assert property (@(posedge clk) disable iff (rst)
        (tmode_w == 2'b10) |-> (tx_mod == rx_demod));

    a_r5_remote_mark: assert property (@(posedge clk) disable iff (rst)
        (tmode_w == 2'b10) |-> rx_data_out);

    a_r6_local_loop: assert property (@(posedge clk) disable iff (rst)
        (tmode_w == 2'b11) |-> (rx_data_out == tx_data_in && tx_mod == tx_data_in));

    a_r8_powerdown_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd1 && wr_data[2]) |=>
        (cfg_r0 == 8'h00 && cfg_r1 == 8'h00 && cfg_r2 == 8'h00 && cfg_tone == 8'h00
         && (cfg_r3 & 8'hFB) == 8'h00 && cfg_r3[2] == $past(cfg_r3[2])));

    a_r9_div_only_phase_mod: assert property (@(posedge clk) disable iff (rst)
        $rose(div_sel) |-> (cfg_r1[3] && mode != 3'd3 && mode != 3'd4));

    a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd0) |=> (cfg_r0 == $past(wr_data)));

endmodule

bind modem_ctl modem_ctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .tmode_w     (tmode_w),
    .tx_data_in  (tx_data_in),
    .rx_demod    (rx_demod),
    .tx_mod      (tx_mod),
    .rx_data_out (rx_data_out),
    .mode        (mode),
    .div_sel     (div_sel),
    .cfg_r0      (cfg_r0),
    .cfg_r1      (cfg_r1),
    .cfg_r2      (cfg_r2),
    .cfg_r3      (cfg_r3),
    .cfg_tone    (cfg_tone)
);

// File: tb/modem_ctl_bench.sv
module modem_ctl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tx_data_in = 1'b0;
    logic       rx_demod = 1'b0;
    logic       tx_mod, rx_data_out, rx_use_tx_carrier, line_mute, clk_pin;
    logic [2:0] mode;
    logic [7:0] cfg_r0, cfg_r1, cfg_r2, cfg_r3, cfg_tone;

    int checks = 0;
    int errors = 0;
    int short_pulses = 0;
    bit finished = 0;
    realtime t_rise = 0.0;

    typedef enum int {S_MODE, S_TXMOD, S_RXOUT, S_CARR, S_MUTE,
                      S_R0, S_R1, S_R2, S_R3, S_TONE} sig_e;
    typedef struct {
        string tag;
        sig_e  sig;
        int    exp;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    modem_ctl u_modem_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_data_in(tx_data_in), .rx_demod(rx_demod), .tx_mod(tx_mod),
        .rx_data_out(rx_data_out), .rx_use_tx_carrier(rx_use_tx_carrier),
        .line_mute(line_mute), .mode(mode), .clk_pin(clk_pin),
        .cfg_r0(cfg_r0), .cfg_r1(cfg_r1), .cfg_r2(cfg_r2), .cfg_r3(cfg_r3),
        .cfg_tone(cfg_tone)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pick(sig_e s);
        case (s)
            S_MODE:  return int'(mode);
            S_TXMOD: return int'(tx_mod);
            S_RXOUT: return int'(rx_data_out);
            S_CARR:  return int'(rx_use_tx_carrier);
            S_MUTE:  return int'(line_mute);
            S_R0:    return int'(cfg_r0);
            S_R1:    return int'(cfg_r1);
            S_R2:    return int'(cfg_r2);
            S_R3:    return int'(cfg_r3);
            default: return int'(cfg_tone);
        endcase
    endfunction

    task automatic expect_out(string tag, sig_e s, int exp);
        item_t it;
        it.tag = tag; it.sig = s; it.exp = exp;
        sb_q.push_back(it);
    endtask

    // monitor: compares queued expectations in the low phase
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, pick(it.sig), it.exp);
        end
    end

    // R10 pulse-width monitor on the clock pin
    always @(posedge clk_pin) t_rise = $realtime;
    always @(negedge clk_pin) if (!rst && ($realtime - t_rise) < 3.5) short_pulses++;

    task automatic settle();
        @(negedge clk); #2;
    endtask

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic data(bit t, bit r);
        @(posedge clk); #1;
        tx_data_in = t; rx_demod = r;
    endtask

    task automatic xtal_check(string tag);
        @(posedge clk); #2; check(tag, int'(clk_pin), 1);
        @(negedge clk); #2; check(tag, int'(clk_pin), 0);
    endtask

    task automatic measure(string tag, int half);
        int hi = 0;
        int lo = 0;
        int guard = 0;
        @(negedge clk); #1;
        while (clk_pin !== 1'b0 && guard < 3000) begin @(negedge clk); #1; guard++; end
        while (clk_pin !== 1'b1 && guard < 3000) begin @(negedge clk); #1; guard++; end
        while (clk_pin === 1'b1 && guard < 3000) begin hi++; @(negedge clk); #1; guard++; end
        while (clk_pin === 1'b0 && guard < 3000) begin lo++; @(negedge clk); #1; guard++; end
        check({tag, " high"}, hi, half);
        check({tag, " low"}, lo, half);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R11 reset state
        expect_out("R11 reset mode", S_MODE, 1);
        expect_out("R11 reset r3", S_R3, 0);
        expect_out("R7 reset mute", S_MUTE, 1);
        expect_out("R7 reset carrier", S_CARR, 0);
        settle();
        xtal_check("R9 reset xtal");

        // R3 normal routing
        data(1, 0);
        expect_out("R3 normal tx", S_TXMOD, 1);
        expect_out("R3 normal rx", S_RXOUT, 0);
        settle();
        data(0, 1);
        expect_out("R3 normal tx", S_TXMOD, 0);
        expect_out("R3 normal rx", S_RXOUT, 1);
        settle();

        // R1 / R2 mode decode
        wr(0, 8'h40); expect_out("R1 qam", S_MODE, 0); settle();
        wr(0, 8'h00); expect_out("R1 dpsk", S_MODE, 1); settle();
        wr(0, 8'h80); expect_out("R2 dpsk600", S_MODE, 2); settle();
        wr(0, 8'h20); expect_out("R1 fsk v23", S_MODE, 3); settle();
        wr(0, 8'hA0); expect_out("R2 fsk v21", S_MODE, 4); settle();
        wr(0, 8'hC0); expect_out("R2 qam opt1", S_MODE, 0); settle();
        wr(0, 8'h60); expect_out("R1 fam11", S_MODE, 1); settle();

        // R7 transmit enable and analog loopback
        wr(0, 8'h02); expect_out("R7 txen mute", S_MUTE, 0); settle();
        wr(1, 8'h01);
        expect_out("R7 aloop carrier", S_CARR, 1);
        expect_out("R7 aloop mute", S_MUTE, 0);
        settle();
        data(1, 0);
        expect_out("R3 aloop tx", S_TXMOD, 1);
        expect_out("R3 aloop rx", S_RXOUT, 0);
        settle();
        wr(0, 8'h00); expect_out("R7 aloop muted", S_MUTE, 1); settle();

        // R4 / R5 remote loopback
        wr(1, 8'h02);
        data(1, 0);
        expect_out("R4 remote tx", S_TXMOD, 0);
        expect_out("R5 remote mark", S_RXOUT, 1);
        expect_out("R7 remote carrier", S_CARR, 0);
        settle();
        data(0, 1);
        expect_out("R4 remote tx", S_TXMOD, 1);
        expect_out("R5 remote mark", S_RXOUT, 1);
        settle();
        data(1, 1);
        expect_out("R4 remote tx ignores input", S_TXMOD, 1);
        settle();

        // R6 local loopback
        wr(1, 8'h03);
        data(0, 1);
        expect_out("R6 local rx", S_RXOUT, 0);
        expect_out("R6 local tx", S_TXMOD, 0);
        settle();
        data(1, 0);
        expect_out("R6 local rx", S_RXOUT, 1);
        expect_out("R6 local tx", S_TXMOD, 1);
        settle();

        // R11 change lands on the write edge, not earlier
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h00;
        expect_out("R11 before edge", S_RXOUT, 1);
        @(posedge clk); #1;
        wr_en = 1'b0;
        expect_out("R11 after edge", S_RXOUT, 0);
        settle();

        // R9 clock pin
        wr(0, 8'h40); wr(1, 8'h08);
        repeat (1200) @(posedge clk);
        measure("R9 qam2400", 144);
        wr(0, 8'h00);
        repeat (1200) @(posedge clk);
        measure("R9 dpsk1200", 288);
        wr(0, 8'h80);
        repeat (1200) @(posedge clk);
        measure("R9 dpsk600", 576);
        wr(0, 8'h20);
        repeat (1300) @(posedge clk);
        xtal_check("R9 fsk xtal");

        // R8 power-down
        wr(0, 8'h80); wr(2, 8'h5A); wr(3, 8'h07); wr(4, 8'h33); wr(1, 8'h08);
        repeat (1200) @(posedge clk);
        wr(1, 8'h0C);
        expect_out("R8 r0", S_R0, 0);
        expect_out("R8 r1", S_R1, 0);
        expect_out("R8 r2", S_R2, 0);
        expect_out("R8 r3 keep", S_R3, 4);
        expect_out("R8 tone", S_TONE, 0);
        expect_out("R8 mode", S_MODE, 1);
        settle();
        repeat (1300) @(posedge clk);
        xtal_check("R8 clock back to xtal");

        // R11 unused address ignored
        wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
        expect_out("R11 ignored r0", S_R0, 0);
        expect_out("R11 ignored r1", S_R1, 0);
        expect_out("R11 ignored r3", S_R3, 4);
        expect_out("R11 ignored tone", S_TONE, 0);
        settle();

        // R11 hardware reset clears the kept bit
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        expect_out("R11 hw reset r3", S_R3, 0);
        settle();

        check("R10 no short clock pulse", short_pulses, 0);
        settle();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule